// File: doc/BRIEF.md
# One-of-N Input Change Counter with Retriggerable Pulse

This block watches a small group of level inputs. At most one of them is expected to be high at any moment. It reacts whenever the asserted input becomes a different one. Each such change advances an event counter by one and starts an output pulse of fixed length. The pulse length is a parameter in clock cycles; 1250 cycles gives 25 µs at a 50 MHz clock. A change that arrives while the pulse is still high restarts the full interval.

The raw inputs and a separate clear input are first brought into the clock domain through a flip-flop chain. A parameter can add a debounce filter behind that chain. The block remembers the most recently asserted input, so a gap where all inputs are low is not an event. Coming back to the same input after such a gap is not an event either. The counter is cleared by a rising edge of the clear input, not by its level, so the counter keeps counting while clear is held high. The asynchronous active-low reset clears all state at once, and its release is synchronised to the clock.

Top module: `chan_change_counter`

## Requirements
- R1: A synchronised input word counts as a selection only when exactly one bit is high. Bit i of `sel_raw` stands for input i. A word with two or more bits high is ignored and leaves the remembered input unchanged.
- R2: When a valid selection differs from the remembered input, `evt_count` increases by exactly one. The first selection after reset counts, because the remembered input starts as none.
- R3: Holding the same input is not counted. Dropping to all-low is not counted. Returning to the same input after all-low is not counted.
- R4: Each counted change drives `pulse_out` high for exactly PULSE_CYC consecutive cycles. It rises in the same cycle that `evt_count` changes. Once the interval ends, the pulse stays low until the next counted change.
- R5: A counted change while `pulse_out` is high restarts the full PULSE_CYC interval from that change.
- R6: A 0-to-1 transition of `clr_raw` sets `evt_count` to 0. While `clr_raw` stays high, later changes count normally and are not cleared.
- R7: When a clear rising edge and a counted change take effect in the same cycle, `evt_count` becomes 1.
- R8: `evt_count` is CNT_W bits wide (16 by default) and wraps from all-ones to 0.
- R9: With the default two-stage synchroniser and no debounce, a raw input change shows at the outputs after the third rising clock edge, and not earlier.
- R10: While `rst_n` is low, `evt_count` is 0 and `pulse_out` is 0. Both take these values as soon as reset is asserted, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel_raw | input | N_IN | Raw one-of-N inputs, bit i is input i |
| clr_raw | input | 1 | Raw counter clear; acts on its rising edge |
| evt_count | output | CNT_W | Number of counted input changes |
| pulse_out | output | 1 | Retriggerable one-shot pulse |

## Verification
The remembered input is internal state. If it held the wrong value, a return to the same input after an idle gap would be counted, or a real change would be missed. The count would then differ from the model three cycles after that stimulus. A stale copy of the previous clear level would show up as a second clear while clear is held high, visible on the next counted change. A pulse timer that wraps or reloads wrongly would show a pulse edge one or more cycles away from its expected place. The bench therefore checks the pulse in every cycle around the end of its interval.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

  // control bundle passed from the front end to the event counter
  typedef struct packed {
    logic evt;      // counted change this cycle
    logic clr_lvl;  // synchronised clear level
  } ctr_ctl_t;

  localparam int unsigned CCC_MIN_SYNC = 2;

endpackage

// File: rtl/ccc_rst_sync.sv
module ccc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_n_o = rs_q[1];

endmodule

// File: rtl/ccc_in_cond.sv
module ccc_in_cond #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter int unsigned DB_CYC = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);

  localparam int unsigned DBW = (DB_CYC > 1) ? $clog2(DB_CYC) : 1;

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] syn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= din_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign syn = stg_q[STAGES-1];

  generate
    if (DB_CYC == 0) begin : g_nodb
      assign dout_o = syn;
    end else begin : g_db
      for (genvar b = 0; b < int'(W); b++) begin : g_bit
        logic [DBW-1:0] cnt_q, cnt_d;
        logic           stb_q, stb_d;

        always_comb begin
          cnt_d = cnt_q;
          stb_d = stb_q;
          if (syn[b] == stb_q) begin
            cnt_d = '0;
          end else if (cnt_q == DBW'(DB_CYC - 1)) begin
            stb_d = syn[b];
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + DBW'(1);
          end
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            cnt_q <= '0;
            stb_q <= 1'b0;
          end else begin
            cnt_q <= cnt_d;
            stb_q <= stb_d;
          end
        end

        assign dout_o[b] = stb_q;
      end
    end
  endgenerate

endmodule

// File: rtl/ccc_change_det.sv
module ccc_change_det #(
  parameter int unsigned N_IN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] sel_i,
  output logic            evt_o
);

  logic [N_IN-1:0] last_q, last_d;
  logic            last_en;
  logic            valid;

  always_comb begin
    valid   = ($countones(sel_i) == 1);
    evt_o   = valid && (sel_i != last_q);
    last_en = evt_o;
    last_d  = last_en ? sel_i : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else begin
      last_q <= last_d;
    end
  end

  AST_LAST_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(last_q)); // R1
  AST_EVT_TAKES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> (last_q == $past(sel_i)) && ($countones(last_q) == 1)); // R2
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0) |=> $stable(last_q)); // R3

endmodule

// File: rtl/ccc_event_ctr.sv
module ccc_event_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ccc_pkg::ctr_ctl_t ctl_i,
  output logic [CNT_W-1:0]  count_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clr_prev_q;
  logic             clr_rise;

  always_comb begin
    clr_rise = ctl_i.clr_lvl && !clr_prev_q;
    cnt_d    = cnt_q;
    if (clr_rise) begin
      cnt_d = ctl_i.evt ? CNT_W'(1) : '0;
    end else if (ctl_i.evt) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      clr_prev_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      clr_prev_q <= ctl_i.clr_lvl;
    end
  end

  assign count_o = cnt_q;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.evt && !(ctl_i.clr_lvl && !clr_prev_q)) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_HOLD_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_i.evt && !(ctl_i.clr_lvl && !clr_prev_q)) |=> $stable(cnt_q)); // R3
  AST_CLR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.clr_lvl && !clr_prev_q && !ctl_i.evt) |=> cnt_q == '0); // R6
  AST_CLR_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.clr_lvl && clr_prev_q && ctl_i.evt) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R6
  AST_CLR_AND_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.clr_lvl && !clr_prev_q && ctl_i.evt) |=> cnt_q == CNT_W'(1)); // R7

endmodule

// File: rtl/ccc_oneshot.sv
module ccc_oneshot #(
  parameter int unsigned PULSE_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);

  localparam int unsigned TW = $clog2(PULSE_CYC + 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  always_comb begin
    tmr_en = trig_i || (tmr_q != '0);
    tmr_d  = tmr_q;
    if (trig_i) begin
      tmr_d = TW'(PULSE_CYC);
    end else if (tmr_q != '0) begin
      tmr_d = tmr_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  assign pulse_o = (tmr_q != '0);

  AST_TRIG_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pulse_o); // R4
  AST_TERMINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !pulse_o) |=> !pulse_o); // R4
  AST_RETRIG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && pulse_o) |=> tmr_q == TW'(PULSE_CYC)); // R5

endmodule

// File: rtl/chan_change_counter.sv
module chan_change_counter #(
  parameter int unsigned N_IN        = 4,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PULSE_CYC   = 1250,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DB_CYC      = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  sel_raw,
  input  logic             clr_raw,
  output logic [CNT_W-1:0] evt_count,
  output logic             pulse_out
);

  localparam int unsigned STG = (SYNC_STAGES < ccc_pkg::CCC_MIN_SYNC) ?
                                ccc_pkg::CCC_MIN_SYNC : SYNC_STAGES;

  logic              rst_n_s;
  logic [N_IN-1:0]   sel_s;
  logic              clr_s;
  logic              evt;
  ccc_pkg::ctr_ctl_t ctl;

  ccc_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  ccc_in_cond #(.W(N_IN), .STAGES(STG), .DB_CYC(DB_CYC)) u_sel_cond (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .din_i  (sel_raw),
    .dout_o (sel_s)
  );

  ccc_in_cond #(.W(1), .STAGES(STG), .DB_CYC(DB_CYC)) u_clr_cond (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .din_i  (clr_raw),
    .dout_o (clr_s)
  );

  ccc_change_det #(.N_IN(N_IN)) u_det (
    .clk   (clk),
    .rst_n (rst_n_s),
    .sel_i (sel_s),
    .evt_o (evt)
  );

  always_comb begin
    ctl.evt     = evt;
    ctl.clr_lvl = clr_s;
  end

  ccc_event_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ctl_i   (ctl),
    .count_o (evt_count)
  );

  ccc_oneshot #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .trig_i  (evt),
    .pulse_o (pulse_out)
  );

  AST_PULSE_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (evt_count != $past(evt_count) && evt_count != '0) |-> pulse_out); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (evt_count == '0 && !pulse_out)); // R10

endmodule

// File: tb/sim_chan_change_counter.sv
`timescale 1ns/1ps
module sim_chan_change_counter;

  localparam int P = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  sel_raw;
  logic        clr_raw;
  logic [15:0] evt_count;
  logic        pulse_out;

  always #2 clk = ~clk; // 250 MHz

  chan_change_counter #(.PULSE_CYC(P)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_raw(sel_raw), .clr_raw(clr_raw),
    .evt_count(evt_count), .pulse_out(pulse_out)
  );

  typedef struct {
    int          due;
    logic [15:0] cnt;
    logic        pul;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  // bench model
  logic [15:0] m_cnt;
  logic [3:0]  m_last;
  logic        m_clr_prev;
  int          m_end;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp_v, cyc);
    end
  endtask

  // monitor: pops scoreboard items when their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      mon_e = q.pop_front();
      check({mon_e.tag, " count"}, evt_count, mon_e.cnt);
      check({mon_e.tag, " pulse"}, {15'd0, pulse_out}, {15'd0, mon_e.pul});
    end
  end

  task automatic model_reset();
    m_cnt = 16'd0; m_last = 4'd0; m_clr_prev = 1'b0; m_end = 0;
  endtask

  // driver: applies one cycle of stimulus and pushes expected results
  task automatic step(input logic [3:0] s, input logic c, input bit push,
                      input bit early, input string tag);
    bit   ev;
    bit   rise;
    exp_t e;
    @(negedge clk);
    sel_raw = s;
    clr_raw = c;
    if (early) begin
      e.due = cyc + 2; e.cnt = m_cnt; e.pul = (cyc + 2 < m_end); e.tag = {tag, " early"};
      q.push_back(e);
    end
    ev   = ($countones(s) == 1) && (s != m_last);
    rise = c && !m_clr_prev;
    m_clr_prev = c;
    if (ev) begin
      m_last = s;
      m_end  = cyc + 3 + P;
    end
    if (rise) m_cnt = ev ? 16'd1 : 16'd0;
    else if (ev) m_cnt = m_cnt + 16'd1;
    if (push) begin
      e.due = cyc + 3; e.cnt = m_cnt; e.pul = (cyc + 3 < m_end); e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic hold(input int n, input string tag);
    for (int i = 0; i < n; i++) step(sel_raw, clr_raw, 1'b1, 1'b0, tag);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_raw = 4'd0; clr_raw = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    check("R10 reset count", evt_count, 16'd0);
    check("R10 reset pulse", {15'd0, pulse_out}, 16'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 first selection counts; R9 not visible before third edge
    step(4'b0001, 1'b0, 1'b1, 1'b1, "R2/R9 first select");
    hold(4, "R3 hold same input");
    step(4'b0000, 1'b0, 1'b1, 1'b0, "R3 idle not counted");
    hold(2, "R3 idle");
    step(4'b0001, 1'b0, 1'b1, 1'b0, "R3 return same input");
    step(4'b0100, 1'b0, 1'b1, 1'b1, "R2/R9 change to input2");
    step(4'b0110, 1'b0, 1'b1, 1'b0, "R1 two bits high ignored");
    step(4'b0100, 1'b0, 1'b1, 1'b0, "R1 remembered input kept");
    step(4'b1010, 1'b0, 1'b1, 1'b0, "R1 multi-high ignored");
    step(4'b1000, 1'b0, 1'b1, 1'b0, "R2 change to input3");
    hold(P + 6, "R4 pulse length");

    // R5 retrigger
    step(4'b0001, 1'b0, 1'b1, 1'b0, "R5 first trigger");
    hold(20, "R5 mid pulse");
    step(4'b0010, 1'b0, 1'b1, 1'b0, "R5 retrigger");
    hold(P + 4, "R5 restarted interval");

    // R6 clear on rising edge, level held
    step(4'b0010, 1'b1, 1'b1, 1'b0, "R6 clear edge");
    hold(3, "R6 clear held");
    step(4'b0001, 1'b1, 1'b1, 1'b0, "R6 count while clear high");
    step(4'b0010, 1'b1, 1'b1, 1'b0, "R6 count while clear high");
    hold(3, "R6 clear held");
    step(4'b0010, 1'b0, 1'b1, 1'b0, "R6 clear released");
    step(4'b0100, 1'b1, 1'b1, 1'b0, "R7 clear and change together");
    hold(4, "R7 after");
    step(4'b0100, 1'b0, 1'b1, 1'b0, "R7 release");
    drain();

    // R8 wrap
    while (m_cnt != 16'hFFFE)
      step((m_last == 4'b0001) ? 4'b0010 : 4'b0001, 1'b0, 1'b0, 1'b0, "R8");
    step((m_last == 4'b0001) ? 4'b0010 : 4'b0001, 1'b0, 1'b1, 1'b0, "R8 at all-ones");
    step((m_last == 4'b0001) ? 4'b0010 : 4'b0001, 1'b0, 1'b1, 1'b0, "R8 wrap to zero");
    step((m_last == 4'b0001) ? 4'b0010 : 4'b0001, 1'b0, 1'b1, 1'b0, "R8 after wrap");
    drain();

    // R10 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async reset count", evt_count, 16'd0);
    check("R10 async reset pulse", {15'd0, pulse_out}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    sel_raw = 4'd0;
    model_reset();
    repeat (5) @(negedge clk);
    step(4'b1000, 1'b0, 1'b1, 1'b0, "R2 first select after reset");
    hold(3, "R3 hold after reset");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule